// File: doc/BRIEF.md
# Selectable Interval Event Generator

This block watches a timekeeping source and emits a one-cycle pulse each time a chosen interval condition occurs. The pulse is meant to set an interval interrupt flag held elsewhere. That flag raises an interrupt only when the interval enable is set. A 2-bit select picks the condition. A mode input decides how the select is read.

In calendar mode the block takes minute-change and hour-change strobes plus the current hour, minute and second in 24-hour binary form. The select then picks minute change, hour change, midnight or noon. In counter mode the block takes a free-running counter value and its increment strobe. The select then picks an overflow out of the lowest quarter, half, three quarters or the full width of that counter.

The calendar counters, the interval counter and the flag register are outside this block.

Top module: `interval_event_gen`

## Requirements
- R1: During and after reset `eventPulse` is 0. If the time inputs already read 00:00:00 or 12:00:00 when reset is released, no midnight or noon pulse follows until the time has left that value and returned to it.
- R2: `eventPulse` is registered. It is high for exactly the one clock cycle after the clock edge that samples the selected condition.
- R3: With `calMode`=1 and `evtSel`=0, a cycle with `minStrobe`=1 produces a pulse.
- R4: With `calMode`=1 and `evtSel`=1, a cycle with `hourStrobe`=1 produces a pulse. `minStrobe` alone produces none.
- R5: With `calMode`=1 and `evtSel`=2, the first cycle in which hour, minute and second are all zero produces one pulse. Holding that time produces no further pulse.
- R6: With `calMode`=1 and `evtSel`=3, the first cycle in which the time reads hour 12, minute 0, second 0 produces one pulse. Midnight produces no pulse under this select.
- R7: With `calMode`=0, `evtSel`=k (k = 0..3) selects overflow of the low 8·(k+1) bits of `cntVal`. A pulse follows a cycle with `cntIncr`=1 in which those low bits are all ones.
- R8: In counter mode the calendar strobes and time inputs have no effect. In calendar mode `cntIncr` and `cntVal` have no effect.
- R9: Changing `evtSel` while the time is held at midnight or noon produces no pulse on its own.
- R10: In counter mode, no pulse follows a cycle with `cntIncr`=0, whatever the value of `cntVal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calMode | input | 1 | 1 = calendar mode, 0 = counter mode |
| evtSel | input | 2 | Interval event select |
| minStrobe | input | 1 | One-cycle minute-changed strobe |
| hourStrobe | input | 1 | One-cycle hour-changed strobe |
| hourVal | input | 5 | Current hour, binary 0..23 |
| minVal | input | 6 | Current minute, binary 0..59 |
| secVal | input | 6 | Current second, binary 0..59 |
| cntIncr | input | 1 | Counter increments this cycle |
| cntVal | input | 32 | Counter value before the increment |
| eventPulse | output | 1 | One-cycle interval event |

## Verification
The bench holds the time at midnight and at noon for several cycles. A design that compared levels instead of detecting entry would pulse on every one of those cycles. It releases reset with the time already at midnight, which catches a match tracker that resets to "not matched" and so fires a false event. It switches the select onto midnight while that time is held, which exposes edge detection that is gated by the select and would fire on the switch. For counter mode it presents values whose low 8 bits are all ones under the wider selects, and all-ones values with no increment. A wrong lane width or a missing increment qualifier would pulse in those cases.

// File: rtl/ieg_pkg.sv
package ieg_pkg;
  localparam int NUM_SEL = 4;

  // Condition strobes from datapath to control, one cycle each.
  typedef struct packed {
    logic               minChg;
    logic               hourChg;
    logic               midHit;
    logic               noonHit;
    logic [NUM_SEL-1:0] ovfHit;
  } condStrobes_t;

  localparam logic [1:0] SEL_CAL_MIN   = 2'd0;
  localparam logic [1:0] SEL_CAL_HOUR  = 2'd1;
  localparam logic [1:0] SEL_CAL_MID   = 2'd2;
  localparam logic [1:0] SEL_CAL_NOON  = 2'd3;
endpackage

// File: rtl/ieg_datapath.sv
module ieg_datapath
  import ieg_pkg::*;
#(
  parameter int HOUR_W    = 5,
  parameter int MIN_W     = 6,
  parameter int SEC_W     = 6,
  parameter int CNT_W     = 32,
  parameter int NOON_HOUR = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              minStrobe,
  input  logic              hourStrobe,
  input  logic [HOUR_W-1:0] hourVal,
  input  logic [MIN_W-1:0]  minVal,
  input  logic [SEC_W-1:0]  secVal,
  input  logic              cntIncr,
  input  logic [CNT_W-1:0]  cntVal,
  output condStrobes_t      cond
);
  localparam int LANE_W = CNT_W / NUM_SEL;

  logic atMid, atNoon, zeroMinSec;
  logic prevMid, prevNoon;

  assign zeroMinSec = (minVal == '0) && (secVal == '0);
  assign atMid      = zeroMinSec && (hourVal == '0);
  assign atNoon     = zeroMinSec && (hourVal == HOUR_W'(NOON_HOUR));

  // Trackers start "matched" so a time already at the match is not an entry.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevMid  <= 1'b1;
      prevNoon <= 1'b1;
    end else begin
      prevMid  <= atMid;
      prevNoon <= atNoon;
    end
  end

  assign cond.minChg  = minStrobe;
  assign cond.hourChg = hourStrobe;
  assign cond.midHit  = atMid  && !prevMid;
  assign cond.noonHit = atNoon && !prevNoon;

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_ovf
    localparam int LW = (k + 1) * LANE_W;
    assign cond.ovfHit[k] = cntIncr && (&cntVal[LW-1:0]);
  end
endmodule

// File: rtl/ieg_control.sv
module ieg_control
  import ieg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         calMode,
  input  logic [1:0]   evtSel,
  input  condStrobes_t cond,
  output logic         eventPulse
);
  logic selHit;

  always_comb begin
    if (calMode) begin
      unique case (evtSel)
        SEL_CAL_MIN:  selHit = cond.minChg;
        SEL_CAL_HOUR: selHit = cond.hourChg;
        SEL_CAL_MID:  selHit = cond.midHit;
        default:      selHit = cond.noonHit;
      endcase
    end else begin
      selHit = cond.ovfHit[evtSel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) eventPulse <= 1'b0;
    else       eventPulse <= selHit;
  end
endmodule

// File: rtl/interval_event_gen.sv
module interval_event_gen
  import ieg_pkg::*;
#(
  parameter int HOUR_W    = 5,
  parameter int MIN_W     = 6,
  parameter int SEC_W     = 6,
  parameter int CNT_W     = 32,
  parameter int NOON_HOUR = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calMode,
  input  logic [1:0]        evtSel,
  input  logic              minStrobe,
  input  logic              hourStrobe,
  input  logic [HOUR_W-1:0] hourVal,
  input  logic [MIN_W-1:0]  minVal,
  input  logic [SEC_W-1:0]  secVal,
  input  logic              cntIncr,
  input  logic [CNT_W-1:0]  cntVal,
  output logic              eventPulse
);
  condStrobes_t cond;

  ieg_datapath #(
    .HOUR_W(HOUR_W), .MIN_W(MIN_W), .SEC_W(SEC_W),
    .CNT_W(CNT_W), .NOON_HOUR(NOON_HOUR)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .minStrobe(minStrobe), .hourStrobe(hourStrobe),
    .hourVal(hourVal), .minVal(minVal), .secVal(secVal),
    .cntIncr(cntIncr), .cntVal(cntVal),
    .cond(cond)
  );

  ieg_control u_ctl (
    .clk(clk), .rstN(rstN),
    .calMode(calMode), .evtSel(evtSel),
    .cond(cond),
    .eventPulse(eventPulse)
  );
endmodule

// File: rtl/ieg_checker.sv
module ieg_checker #(
  parameter int HOUR_W = 5,
  parameter int MIN_W  = 6,
  parameter int SEC_W  = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              calMode,
  input logic [1:0]        evtSel,
  input logic              minStrobe,
  input logic              hourStrobe,
  input logic [HOUR_W-1:0] hourVal,
  input logic [MIN_W-1:0]  minVal,
  input logic [SEC_W-1:0]  secVal,
  input logic              cntIncr,
  input logic [CNT_W-1:0]  cntVal,
  input logic              eventPulse
);
  localparam int LANE_W = CNT_W / 4;

  // R3: minute strobe under minute select gives a pulse next cycle
  assert_min_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (calMode && evtSel == 2'd0 && minStrobe) |=> eventPulse);

  // R4: hour strobe under hour select gives a pulse next cycle
  assert_hour_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (calMode && evtSel == 2'd1 && hourStrobe) |=> eventPulse);

  // R7: lowest-lane overflow with increment gives a pulse
  assert_ovf_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!calMode && evtSel == 2'd0 && cntIncr && (&cntVal[LANE_W-1:0])) |=> eventPulse);

  // R10: no increment in counter mode means no pulse
  assert_no_incr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!calMode && !cntIncr) |=> !eventPulse);

  // R5: midnight pulse is not repeated while the selection is held
  assert_mid_once_R5: assert property (@(posedge clk) disable iff (!rstN)
    (eventPulse && calMode && evtSel == 2'd2 && $stable(evtSel) && $stable(calMode))
      |=> !eventPulse);

  // R6: noon pulse is not repeated while the selection is held
  assert_noon_once_R6: assert property (@(posedge clk) disable iff (!rstN)
    (eventPulse && calMode && evtSel == 2'd3 && $stable(evtSel) && $stable(calMode))
      |=> !eventPulse);
endmodule

bind interval_event_gen ieg_checker #(
  .HOUR_W(HOUR_W), .MIN_W(MIN_W), .SEC_W(SEC_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .calMode(calMode), .evtSel(evtSel),
  .minStrobe(minStrobe), .hourStrobe(hourStrobe),
  .hourVal(hourVal), .minVal(minVal), .secVal(secVal),
  .cntIncr(cntIncr), .cntVal(cntVal), .eventPulse(eventPulse)
);

// File: tb/tb_interval_event_gen.sv
module tb_interval_event_gen;
  logic        clk = 1'b0;
  logic        rstN;
  logic        calMode;
  logic [1:0]  evtSel;
  logic        minStrobe, hourStrobe;
  logic [4:0]  hourVal;
  logic [5:0]  minVal, secVal;
  logic        cntIncr;
  logic [31:0] cntVal;
  logic        eventPulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  interval_event_gen dut (
    .clk(clk), .rstN(rstN), .calMode(calMode), .evtSel(evtSel),
    .minStrobe(minStrobe), .hourStrobe(hourStrobe),
    .hourVal(hourVal), .minVal(minVal), .secVal(secVal),
    .cntIncr(cntIncr), .cntVal(cntVal), .eventPulse(eventPulse)
  );

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (eventPulse !== exp) begin
      errors++;
      $display("FAIL %s: eventPulse=%0b expected=%0b", tag, eventPulse, exp);
    end
  endtask

  // One clock edge, then land on the falling edge for sampling and driving.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setTime(input int h, input int m, input int s);
    hourVal = 5'(h); minVal = 6'(m); secVal = 6'(s);
  endtask

  task automatic testReset();
    rstN = 1'b0; calMode = 1'b1; evtSel = 2'd2;
    minStrobe = 0; hourStrobe = 0; cntIncr = 0; cntVal = '0;
    setTime(0, 0, 0);
    repeat (3) step();
    chk(1'b0, "R1 in reset");
    rstN = 1'b1;
    step(); chk(1'b0, "R1 midnight held at release");
    step(); chk(1'b0, "R1 second cycle after release");
  endtask

  task automatic testMinute();
    setTime(10, 5, 0); evtSel = 2'd0; step();
    minStrobe = 1; step(); chk(1'b1, "R3 minute strobe");
    minStrobe = 0; step(); chk(1'b0, "R2 pulse one cycle wide");
  endtask

  task automatic testHour();
    evtSel = 2'd1;
    minStrobe = 1; step(); chk(1'b0, "R4 minute strobe under hour select");
    minStrobe = 0; hourStrobe = 1; step(); chk(1'b1, "R4 hour strobe");
    hourStrobe = 0; step(); chk(1'b0, "R2 hour pulse ends");
  endtask

  task automatic testMidnight();
    evtSel = 2'd2; setTime(23, 59, 59); step(); chk(1'b0, "R5 before midnight");
    setTime(0, 0, 0); step(); chk(1'b1, "R5 midnight entry");
    step(); chk(1'b0, "R5 midnight held");
    step(); chk(1'b0, "R5 midnight held 2");
  endtask

  task automatic testNoon();
    evtSel = 2'd3; setTime(23, 59, 59); step();
    setTime(0, 0, 0); step(); chk(1'b0, "R6 midnight under noon select");
    setTime(11, 59, 59); step(); chk(1'b0, "R6 before noon");
    setTime(12, 0, 0); step(); chk(1'b1, "R6 noon entry");
    step(); chk(1'b0, "R6 noon held");
  endtask

  task automatic testSelSwitch();
    // Time is held at 12:00:00 from the previous test.
    evtSel = 2'd0; step(); chk(1'b0, "R9 leave noon select");
    evtSel = 2'd3; step(); chk(1'b0, "R9 return to noon select at noon");
    setTime(0, 0, 0); evtSel = 2'd0; step(); step();
    evtSel = 2'd2; step(); chk(1'b0, "R9 switch onto midnight while held");
    step(); chk(1'b0, "R9 switch onto midnight held 2");
  endtask

  task automatic testCounter();
    calMode = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] ones;
      ones = (k == 3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (k + 1))) - 32'h1);
      evtSel = 2'(k);
      cntVal = ones; cntIncr = 1; step(); chk(1'b1, $sformatf("R7 overflow lane %0d", k));
      cntIncr = 0; step(); chk(1'b0, $sformatf("R10 all ones no increment lane %0d", k));
      if (k > 0) begin
        cntVal = 32'h0000_00FF; cntIncr = 1; step();
        chk(1'b0, $sformatf("R7 only low byte full, lane %0d", k));
      end
      cntVal = 32'h0000_0010; cntIncr = 1; step(); chk(1'b0, $sformatf("R7 plain increment lane %0d", k));
      cntIncr = 0;
    end
    cntVal = 32'hFFFF_FFFF; cntIncr = 0; evtSel = 2'd3; step(); chk(1'b0, "R10 full ones held");
  endtask

  task automatic testIsolation();
    calMode = 1'b0; evtSel = 2'd0; cntIncr = 0; cntVal = '0;
    minStrobe = 1; step(); chk(1'b0, "R8 minute strobe in counter mode");
    minStrobe = 0; evtSel = 2'd1; hourStrobe = 1; step(); chk(1'b0, "R8 hour strobe in counter mode");
    hourStrobe = 0; evtSel = 2'd3; setTime(11, 59, 59); step();
    setTime(12, 0, 0); step(); chk(1'b0, "R8 noon entry in counter mode");
    calMode = 1'b1; evtSel = 2'd0; setTime(9, 0, 0);
    cntVal = 32'hFFFF_FFFF; cntIncr = 1; step(); chk(1'b0, "R8 overflow in calendar mode");
    cntIncr = 0; cntVal = '0; step(); chk(1'b0, "R8 quiet");
  endtask

  initial begin
    testReset();
    testMinute();
    testHour();
    testMidnight();
    testNoon();
    testSelSwitch();
    testCounter();
    testIsolation();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule